// File: doc/BRIEF.md
# Synthesizer Test-Mode Clock Selector

This block produces the test pin of a clock synthesizer and can take over the synthesizer's main output. A registered 3-bit mode code selects the test source. The sources are a constant high, a constant low, the serial-out bit of the programming shift register, the reference clock divided by 16, the feedback (M) divider followed by a divide-by-2, a straight copy of the main output, and the main output divided by 4. In the serial-clock mode, the slow programming clock replaces the VCO as the input of both the M divider and the N output divider. The whole divider chain can then be exercised at a low rate, and the N divider result drives the main output.

All source clocks are sampled by one system clock, which must run faster than twice the fastest source in use. A synchronizer brings each source in, and every divider advances on a detected rising edge. Any change of the mode code clears every divider, so the newly selected divided output always begins low.

Top module: `tsel_top`

## Requirements
- R1: With mode code 000 the test output equals the shift-register serial-out input; this is also the mode selected after reset.
- R2: Mode code 001 holds the test output high and mode code 101 holds it low, whatever the source clocks do.
- R3: Mode code 010 gives the reference clock divided by 16 with 50% duty: the output is high from the 8th to the 15th reference edge after a restart and low again at the 16th.
- R4: Mode code 011 gives the VCO clock divided by M and then by 2: the test output rises at VCO edges M, 3M, 5M and so on. An M value of 0 acts as 1.
- R5: Mode code 100 copies the main output clock to the test output.
- R6: Mode code 110 gives the serial clock divided by M and then by 2 on the test output. The main output carries the serial clock divided by N, where the N code 00 means ÷1, 01 ÷2, 10 ÷4 and 11 ÷8, each with 50% duty.
- R7: In every mode except 110, the main output follows the main clock input.
- R8: Mode code 111 gives the main clock divided by 4 on the test output.
- R9: Any change of the mode code clears all divider counters. In a divided mode the test output is low in the cycle after the change, and its first rise comes only after the full half-division count of new source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_code | input | 3 | Test mode code |
| m_val | input | MW (9) | Feedback divider value |
| n_code | input | NW (2) | Output divider code, log2 of the ratio |
| sr_out | input | 1 | Serial-out bit of the programming shift register |
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | VCO-rate clock |
| sclk | input | 1 | Serial programming clock |
| fout_in | input | 1 | Main output clock before override |
| test_out | output | 1 | Test output |
| main_out | output | 1 | Main output after override |

## Verification
A wrong count in any divider shows at the ports as an output edge count that is off over a known number of source edges. The bench compares edge totals after tens of source edges, so an error is caught within one division period. A restart that does not clear a divider leaves a counter part-way through its count, and the first output rise arrives early. The bench checks the level one edge before and one edge after the expected rise. A mode register that goes to the wrong source shows in the very next sampled level, in the constant and copy modes.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
   typedef enum logic [2:0] {
      TM_SHIFT  = 3'b000,
      TM_HIGH   = 3'b001,
      TM_REFDIV = 3'b010,
      TM_FBDIV  = 3'b011,
      TM_FCOPY  = 3'b100,
      TM_LOW    = 3'b101,
      TM_SCLK   = 3'b110,
      TM_FQUART = 3'b111
   } tmode_e;
endpackage

// File: rtl/tsel_sync.sv
module tsel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("tsel_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = sh[STAGES-1];
endmodule

// File: rtl/tsel_p2div.sv
module tsel_p2div #(
   parameter int MAXLOG = 4,
   localparam int LW    = $clog2(MAXLOG + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          src_lvl,
   input  logic [LW-1:0] sel,
   output logic          out
);
   logic [MAXLOG-1:0] cnt;
   logic              prev;
   logic              rise;

   generate
      if (MAXLOG < 1) begin : g_bad_log
         $error("tsel_p2div: MAXLOG must be at least 1");
      end
   endgenerate

   assign rise = src_lvl & ~prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         prev <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         prev <= src_lvl;
      end else begin
         prev <= src_lvl;
         if (rise) cnt <= cnt + 1'b1;
      end
   end

   always_comb begin
      out = src_lvl;
      for (int i = 1; i <= MAXLOG; i++) begin
         if (sel == LW'(i)) out = cnt[i-1];
      end
   end
endmodule

// File: rtl/tsel_mdiv.sv
module tsel_mdiv #(
   parameter int MW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          src_lvl,
   input  logic [MW-1:0] m,
   output logic          out
);
   logic [MW-1:0] cnt;
   logic [MW-1:0] lim;
   logic          prev;
   logic          tog;
   logic          rise;

   generate
      if (MW < 2) begin : g_bad_mw
         $error("tsel_mdiv: MW must be at least 2");
      end
   endgenerate

   assign rise = src_lvl & ~prev;
   assign lim  = (m == '0) ? '0 : m - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         prev <= 1'b0;
         tog  <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         prev <= src_lvl;
         tog  <= 1'b0;
      end else begin
         prev <= src_lvl;
         if (rise) begin
            if (cnt >= lim) begin
               cnt <= '0;
               tog <= ~tog;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign out = tog;
endmodule

// File: rtl/tsel_top.sv
module tsel_top
   import tsel_pkg::*;
#(
   parameter int MW          = 9,
   parameter int NW          = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REF_LOG2    = 4,
   parameter int FOUT_LOG2   = 2,
   localparam int NMAX      = (1 << NW) - 1,
   localparam int REF_LW    = $clog2(REF_LOG2 + 1),
   localparam int FOUT_LW   = $clog2(FOUT_LOG2 + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    t_code,
   input  logic [MW-1:0] m_val,
   input  logic [NW-1:0] n_code,
   input  logic          sr_out,
   input  logic          ref_clk,
   input  logic          vco_clk,
   input  logic          sclk,
   input  logic          fout_in,
   output logic          test_out,
   output logic          main_out
);
   tmode_e t_q;
   logic   restart;
   logic   ref_s, vco_s, sclk_s, fout_s;
   logic   m_src;
   logic   ref_div, m_div, n_div, fout_div;

   generate
      if (NW < 1) begin : g_bad_nw
         $error("tsel_top: NW must be at least 1");
      end
      if (REF_LOG2 < 1 || FOUT_LOG2 < 1) begin : g_bad_fixed
         $error("tsel_top: fixed divider exponents must be at least 1");
      end
   endgenerate

   assign restart = (t_code != t_q);

   always_ff @(posedge clk) begin
      if (!rst_n) t_q <= TM_SHIFT;
      else        t_q <= tmode_e'(t_code);
   end

   tsel_sync #(.STAGES(SYNC_STAGES)) u_sync_ref  (.clk, .rst_n, .din(ref_clk), .dout(ref_s));
   tsel_sync #(.STAGES(SYNC_STAGES)) u_sync_vco  (.clk, .rst_n, .din(vco_clk), .dout(vco_s));
   tsel_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (.clk, .rst_n, .din(sclk),    .dout(sclk_s));
   tsel_sync #(.STAGES(SYNC_STAGES)) u_sync_fout (.clk, .rst_n, .din(fout_in), .dout(fout_s));

   assign m_src = (t_q == TM_SCLK) ? sclk_s : vco_s;

   tsel_p2div #(.MAXLOG(REF_LOG2)) u_refdiv (
      .clk, .rst_n, .clr(restart), .src_lvl(ref_s),
      .sel(REF_LW'(REF_LOG2)), .out(ref_div)
   );

   tsel_mdiv #(.MW(MW)) u_mdiv (
      .clk, .rst_n, .clr(restart), .src_lvl(m_src), .m(m_val), .out(m_div)
   );

   tsel_p2div #(.MAXLOG(NMAX)) u_ndiv (
      .clk, .rst_n, .clr(restart), .src_lvl(sclk_s), .sel(n_code), .out(n_div)
   );

   tsel_p2div #(.MAXLOG(FOUT_LOG2)) u_foutdiv (
      .clk, .rst_n, .clr(restart), .src_lvl(fout_s),
      .sel(FOUT_LW'(FOUT_LOG2)), .out(fout_div)
   );

   always_comb begin
      unique case (t_q)
         TM_SHIFT:  test_out = sr_out;
         TM_HIGH:   test_out = 1'b1;
         TM_REFDIV: test_out = ref_div;
         TM_FBDIV:  test_out = m_div;
         TM_FCOPY:  test_out = fout_in;
         TM_LOW:    test_out = 1'b0;
         TM_SCLK:   test_out = m_div;
         TM_FQUART: test_out = fout_div;
         default:   test_out = 1'b0;
      endcase
   end

   assign main_out = (t_q == TM_SCLK) ? n_div : fout_in;
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] t_code,
   input logic [2:0] t_q,
   input logic       restart,
   input logic       sr_out,
   input logic       fout_in,
   input logic       test_out,
   input logic       main_out
);
   p_serial_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q == 3'b000) |-> (test_out == sr_out));

   p_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q == 3'b001) |-> test_out);

   p_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q == 3'b101) |-> !test_out);

   p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q == 3'b100) |-> (test_out == fout_in));

   p_main_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (t_q != 3'b110) |-> (main_out == fout_in));

   p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && (t_code == 3'b010 || t_code == 3'b011 ||
                   t_code == 3'b110 || t_code == 3'b111)) |=> !test_out);
endmodule

bind tsel_top tsel_chk u_tsel_chk (
   .clk(clk), .rst_n(rst_n), .t_code(t_code), .t_q(t_q), .restart(restart),
   .sr_out(sr_out), .fout_in(fout_in), .test_out(test_out), .main_out(main_out)
);

// File: tb/test_tsel_top.sv
module test_tsel_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] t_code = 3'b000;
   logic [8:0] m_val = 9'd5;
   logic [1:0] n_code = 2'b00;
   logic       sr_out = 1'b0;
   logic       ref_clk = 1'b0;
   logic       vco_clk = 1'b0;
   logic       sclk = 1'b0;
   logic       fout_in = 1'b0;
   logic       test_out;
   logic       main_out;

   int n_checks = 0;
   int n_fail = 0;
   int t_rises = 0;
   int m_rises = 0;
   logic t_prev = 1'b0;
   logic m_prev = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tsel_top i_tsel_top (
      .clk, .rst_n, .t_code, .m_val, .n_code, .sr_out,
      .ref_clk, .vco_clk, .sclk, .fout_in, .test_out, .main_out
   );

   always @(negedge clk) begin
      if (test_out && !t_prev) t_rises++;
      if (main_out && !m_prev) m_rises++;
      t_prev = test_out;
      m_prev = main_out;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_src(input int which, input logic v);
      case (which)
         0: ref_clk = v;
         1: vco_clk = v;
         2: sclk = v;
         default: fout_in = v;
      endcase
   endtask

   task automatic edges(input int which, input int e);
      for (int i = 0; i < e; i++) begin
         @(posedge clk); #2 set_src(which, 1'b1);
         repeat (2) @(posedge clk);
         #2 set_src(which, 1'b0);
         @(posedge clk);
      end
      repeat (6) @(posedge clk);
   endtask

   task automatic set_mode(input logic [2:0] t);
      @(posedge clk); #2 t_code = t ^ 3'b111;
      repeat (3) @(posedge clk);
      #2 t_code = t;
      repeat (3) @(posedge clk);
   endtask

   task automatic level_is(input logic exp, input string req);
      @(negedge clk);
      check(test_out === exp, req, int'(test_out), int'(exp));
   endtask

   function automatic int p2_rises(input int e, input int d);
      return (e + d / 2) / d;
   endfunction

   function automatic int m_rises_exp(input int e, input int m);
      int mm;
      mm = (m == 0) ? 1 : m;
      return (e / mm + 1) / 2;
   endfunction

   task automatic t_reset_state;
      @(negedge clk);
      check(test_out === 1'b0, "R1 reset sr_out=0", int'(test_out), 0);
      check(main_out === fout_in, "R7 reset main follows fout", int'(main_out), int'(fout_in));
      @(posedge clk); #2 sr_out = 1'b1;
      level_is(1'b1, "R1 serial-out high");
      @(posedge clk); #2 sr_out = 1'b0;
      level_is(1'b0, "R1 serial-out low");
   endtask

   task automatic t_constants;
      int r0;
      set_mode(3'b001);
      level_is(1'b1, "R2 code 001 high");
      set_mode(3'b101);
      r0 = t_rises;
      edges(0, 20);
      edges(3, 4);
      check(t_rises == r0, "R2 code 101 ignores sources", t_rises - r0, 0);
      level_is(1'b0, "R2 code 101 low");
   endtask

   task automatic t_refdiv;
      int r0;
      set_mode(3'b010);
      r0 = t_rises;
      edges(0, 64);
      check(t_rises - r0 == p2_rises(64, 16), "R3 ref/16 rise count", t_rises - r0, p2_rises(64, 16));
   endtask

   task automatic t_fbdiv;
      int r0;
      m_val = 9'd5;
      set_mode(3'b011);
      r0 = t_rises;
      edges(1, 40);
      check(t_rises - r0 == m_rises_exp(40, 5), "R4 vco/(2*5)", t_rises - r0, m_rises_exp(40, 5));
      m_val = 9'd0;
      set_mode(3'b011);
      r0 = t_rises;
      edges(1, 6);
      check(t_rises - r0 == m_rises_exp(6, 0), "R4 M=0 acts as 1", t_rises - r0, m_rises_exp(6, 0));
   endtask

   task automatic t_fcopy;
      int r0, q0;
      set_mode(3'b100);
      r0 = t_rises;
      q0 = m_rises;
      edges(3, 5);
      check(t_rises - r0 == 5, "R5 copy of main clock", t_rises - r0, 5);
      check(m_rises - q0 == 5, "R7 main follows fout", m_rises - q0, 5);
   endtask

   task automatic t_sclk_mode;
      int r0, q0;
      m_val = 9'd3;
      n_code = 2'b10;
      set_mode(3'b110);
      r0 = t_rises;
      q0 = m_rises;
      edges(2, 24);
      check(t_rises - r0 == m_rises_exp(24, 3), "R6 sclk/(2*3) on test", t_rises - r0, m_rises_exp(24, 3));
      check(m_rises - q0 == p2_rises(24, 4), "R6 main sclk/4", m_rises - q0, p2_rises(24, 4));
      q0 = m_rises;
      edges(3, 4);
      check(m_rises == q0, "R6 main ignores fout in 110", m_rises - q0, 0);
      n_code = 2'b00;
      set_mode(3'b110);
      q0 = m_rises;
      edges(2, 5);
      check(m_rises - q0 == 5, "R6 main sclk/1", m_rises - q0, 5);
      n_code = 2'b11;
      set_mode(3'b110);
      q0 = m_rises;
      edges(2, 16);
      check(m_rises - q0 == p2_rises(16, 8), "R6 main sclk/8", m_rises - q0, p2_rises(16, 8));
      n_code = 2'b01;
      set_mode(3'b110);
      q0 = m_rises;
      edges(2, 7);
      check(m_rises - q0 == p2_rises(7, 2), "R6 main sclk/2", m_rises - q0, p2_rises(7, 2));
   endtask

   task automatic t_fquart;
      int r0;
      set_mode(3'b111);
      r0 = t_rises;
      edges(3, 20);
      check(t_rises - r0 == p2_rises(20, 4), "R8 main clock/4", t_rises - r0, p2_rises(20, 4));
   endtask

   task automatic t_restart;
      int r0;
      set_mode(3'b010);
      edges(0, 12);
      level_is(1'b1, "R3 high after 12 ref edges");
      set_mode(3'b010);
      level_is(1'b0, "R9 low after mode change");
      r0 = t_rises;
      edges(0, 7);
      check(t_rises == r0, "R9 no rise before 8th edge", t_rises - r0, 0);
      edges(0, 1);
      level_is(1'b1, "R9 rise at 8th edge");
      edges(0, 7);
      level_is(1'b1, "R3 still high at 15th edge");
      edges(0, 1);
      level_is(1'b0, "R3 low at 16th edge");
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_reset_state();
      t_constants();
      t_refdiv();
      t_fbdiv();
      t_fcopy();
      t_sclk_mode();
      t_fquart();
      t_restart();
      finish_run();
   end

   initial begin
      #(200000 * 8);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule